// File: doc/BRIEF.md
# Repeated-Copy Microcode Sequencer

This block sits between a decoded-op queue and a simplified issue stage. Ordinary decoded operations go through it as single micro-ops. When a repeated-copy macro-instruction reaches the head of the queue, the sequencer takes over the issue port. It expands the instruction into a fixed batch of predicated copy micro-ops, which go out without any condition. It then emits a count-report micro-op that asks the back-end for its live count register. Every predicated micro-op carries its iteration index, so the back-end can disable the ones whose index is not below the real count.

After the report has issued, the sequencer stalls and waits for the back-end to return the count. It never uses a microcode branch. A fixed static rule picks one of three ways to finish. A count of zero closes with a skip marker. A count that fits inside the batch closes with an end marker. A larger count produces exactly the missing copy iterations. The queue keeps accepting new entries from upstream during an expansion; only its dequeue side is held.

Top module: `copy_useq`

## Requirements
- R1: After synchronous reset, `uop_valid` is 0 and `in_ready` is 1.
- R2: An ordinary op (`in_rep`=0) issues as exactly one micro-op with kind 0 (pass), index 0, its own tag and `uop_last`=1.
- R3: A repeated-copy op (`in_rep`=1) first issues exactly BATCH_N micro-ops of kind 1 (predicated copy) with indices 0 to BATCH_N-1 in order, whatever the real count is. These are followed by one micro-op of kind 2 (count report) with index 0.
- R4: From the first to the last micro-op of an expansion, no micro-op of any other instruction issues. During that time `in_ready` stays 1 while the queue has room.
- R5: After the count report issues, `uop_valid` stays 0 until `cnt_valid` is seen. A `cnt_valid` pulse at any other time is ignored and does not change a later expansion.
- R6: A returned count C greater than BATCH_N gives exactly C-BATCH_N micro-ops of kind 3 (copy), with indices BATCH_N to C-1 in order. Only the last of these has `uop_last`=1.
- R7: A returned count from 1 to BATCH_N gives one micro-op of kind 4 (end), with index 0 and `uop_last`=1.
- R8: A returned count of 0 gives one micro-op of kind 5 (skip), with index 0 and `uop_last`=1.
- R9: Every micro-op of an expansion carries the parent instruction's tag. `uop_last` is 1 only on the final micro-op of the expansion.
- R10: While `uop_valid`=1 and `uop_ready`=0, the offered micro-op (valid, kind, index, tag, last) holds unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream decoded op present |
| in_ready | output | 1 | Decoded-op queue has room |
| in_rep | input | 1 | 1 = repeated-copy macro-instruction, 0 = ordinary op |
| in_tag | input | TAG_W | Sequence number of the incoming op |
| uop_valid | output | 1 | Micro-op offered to the issue stage |
| uop_ready | input | 1 | Issue stage takes the micro-op |
| uop_kind | output | 3 | 0 pass, 1 predicated copy, 2 count report, 3 copy, 4 end, 5 skip |
| uop_idx | output | CNT_W | Copy iteration index |
| uop_tag | output | TAG_W | Parent instruction sequence number |
| uop_last | output | 1 | Final micro-op of its instruction |
| cnt_valid | input | 1 | Back-end returns the count |
| cnt_value | input | CNT_W | Returned remaining count |

## Verification
If the expansion state machine goes wrong, the ports show it within one micro-op. A skipped or repeated batch slot appears as a gap or a repeat in the index sequence. A wrong path after the count return appears as the wrong closing kind, or as too few or too many copy micro-ops. If the wait state were left early, `uop_valid` would rise before the count arrives. A stray count accepted outside the wait would change how the next expansion closes. A queue-pointer fault shows up as a pass micro-op out of order, or one placed inside an expansion, as soon as that entry reaches the head.

// File: rtl/copy_useq_pkg.sv
package copy_useq_pkg;

    localparam int DEF_CNT_W = 16;
    localparam int DEF_TAG_W = 8;

    typedef enum logic [2:0] {
        UK_PASS   = 3'd0,
        UK_PRED   = 3'd1,
        UK_REPORT = 3'd2,
        UK_COPY   = 3'd3,
        UK_END    = 3'd4,
        UK_SKIP   = 3'd5
    } uop_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRED,
        ST_REPORT,
        ST_WAIT,
        ST_COPY,
        ST_END,
        ST_SKIP
    } seq_state_e;

    // Static path rule once the count is known: no prediction involved.
    function automatic seq_state_e path_after_count(input logic is_zero, input logic beyond);
        if (is_zero)
            return ST_SKIP;
        else if (beyond)
            return ST_COPY;
        else
            return ST_END;
    endfunction

endpackage

// File: rtl/useq_opq.sv
module useq_opq #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_rep,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic             head_rep,
    output logic [TAG_W-1:0] head_tag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = PTR_W + 1;

    typedef struct packed {
        logic             rep;
        logic [TAG_W-1:0] tag;
    } q_entry_t;

    q_entry_t         store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (occ == OCC_W'(DEPTH));
    assign empty    = (occ == '0);
    assign head_rep = store[rd_ptr].rep;
    assign head_tag = store[rd_ptr].tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= '{rep: push_rep, tag: push_tag};
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            if (push && !pop)
                occ <= occ + 1'b1;
            else if (pop && !push)
                occ <= occ - 1'b1;
        end
    end

    // R4
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    // R4
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/useq_count_path.sv
module useq_count_path #(
    parameter int BATCH_N = 8,
    parameter int CNT_W   = 16
) (
    input  logic [CNT_W-1:0] cnt_value,
    output logic             is_zero,
    output logic             beyond,
    output logic [CNT_W-1:0] final_idx
);
    localparam logic [CNT_W-1:0] BATCH = CNT_W'(BATCH_N);

    assign is_zero   = (cnt_value == '0);
    assign beyond    = (cnt_value > BATCH);
    assign final_idx = cnt_value - 1'b1;

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import copy_useq_pkg::*;
#(
    parameter int BATCH_N = 8,
    parameter int CNT_W   = 16,
    parameter int TAG_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_valid,
    input  logic             head_rep,
    input  logic [TAG_W-1:0] head_tag,
    output logic             pop,
    input  logic             cnt_valid,
    input  logic             cnt_is_zero,
    input  logic             cnt_beyond,
    input  logic [CNT_W-1:0] cnt_final_idx,
    output logic             uop_valid,
    input  logic             uop_ready,
    output uop_kind_e        uop_kind,
    output logic [CNT_W-1:0] uop_idx,
    output logic [TAG_W-1:0] uop_tag,
    output logic             uop_last
);
    localparam logic [CNT_W-1:0] BATCH     = CNT_W'(BATCH_N);
    localparam logic [CNT_W-1:0] LAST_PRED = CNT_W'(BATCH_N - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] idx, lim;
    logic [TAG_W-1:0] tag_q;
    logic             fire;

    assign fire = uop_valid && uop_ready;

    always_comb begin
        uop_valid = 1'b0;
        uop_kind  = UK_PASS;
        uop_idx   = '0;
        uop_tag   = tag_q;
        uop_last  = 1'b0;
        pop       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                uop_valid = head_valid && !head_rep;
                uop_tag   = head_tag;
                uop_last  = 1'b1;
                pop       = head_valid && (head_rep || uop_ready);
            end
            ST_PRED: begin
                uop_valid = 1'b1;
                uop_kind  = UK_PRED;
                uop_idx   = idx;
            end
            ST_REPORT: begin
                uop_valid = 1'b1;
                uop_kind  = UK_REPORT;
            end
            ST_WAIT: ;
            ST_COPY: begin
                uop_valid = 1'b1;
                uop_kind  = UK_COPY;
                uop_idx   = idx;
                uop_last  = (idx == lim);
            end
            ST_END: begin
                uop_valid = 1'b1;
                uop_kind  = UK_END;
                uop_last  = 1'b1;
            end
            ST_SKIP: begin
                uop_valid = 1'b1;
                uop_kind  = UK_SKIP;
                uop_last  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            lim   <= '0;
            tag_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (head_valid && head_rep) begin
                    state <= ST_PRED;
                    idx   <= '0;
                    tag_q <= head_tag;
                end
                ST_PRED: if (fire) begin
                    if (idx == LAST_PRED)
                        state <= ST_REPORT;
                    else
                        idx <= idx + 1'b1;
                end
                ST_REPORT: if (fire)
                    state <= ST_WAIT;
                ST_WAIT: if (cnt_valid) begin
                    state <= path_after_count(cnt_is_zero, cnt_beyond);
                    idx   <= BATCH;
                    lim   <= cnt_final_idx;
                end
                ST_COPY: if (fire) begin
                    if (idx == lim)
                        state <= ST_IDLE;
                    else
                        idx <= idx + 1'b1;
                end
                ST_END, ST_SKIP: if (fire)
                    state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_idx)
                                       && $stable(uop_tag) && $stable(uop_last)));

    // R5
    wait_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && uop_kind == UK_REPORT) |=> !uop_valid);

    // R3
    pred_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && uop_kind == UK_PRED && uop_idx != LAST_PRED)
            |=> (uop_valid && uop_kind == UK_PRED && uop_idx == $past(uop_idx) + 1'b1));

    // R6
    copy_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && uop_kind == UK_COPY && !uop_last)
            |=> (uop_valid && uop_kind == UK_COPY && uop_idx == $past(uop_idx) + 1'b1));

    // R9
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !uop_last) |=> (uop_tag == $past(uop_tag)));

endmodule

// File: rtl/copy_useq.sv
module copy_useq
    import copy_useq_pkg::*;
#(
    parameter int BATCH_N = 8,
    parameter int CNT_W   = DEF_CNT_W,
    parameter int TAG_W   = DEF_TAG_W,
    parameter int QDEPTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_rep,
    input  logic [TAG_W-1:0] in_tag,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [2:0]       uop_kind,
    output logic [CNT_W-1:0] uop_idx,
    output logic [TAG_W-1:0] uop_tag,
    output logic             uop_last,
    input  logic             cnt_valid,
    input  logic [CNT_W-1:0] cnt_value
);
    logic             q_full, q_empty, q_pop, q_head_rep;
    logic [TAG_W-1:0] q_head_tag;
    logic             c_zero, c_beyond;
    logic [CNT_W-1:0] c_final;
    uop_kind_e        kind_e;

    assign in_ready = !q_full;
    assign uop_kind = kind_e;

    useq_opq #(.DEPTH(QDEPTH), .TAG_W(TAG_W)) u_opq (
        .clk      (clk),
        .rst      (rst),
        .push     (in_valid && !q_full),
        .push_rep (in_rep),
        .push_tag (in_tag),
        .pop      (q_pop),
        .full     (q_full),
        .empty    (q_empty),
        .head_rep (q_head_rep),
        .head_tag (q_head_tag)
    );

    useq_count_path #(.BATCH_N(BATCH_N), .CNT_W(CNT_W)) u_path (
        .cnt_value (cnt_value),
        .is_zero   (c_zero),
        .beyond    (c_beyond),
        .final_idx (c_final)
    );

    useq_ctrl #(.BATCH_N(BATCH_N), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .head_valid    (!q_empty),
        .head_rep      (q_head_rep),
        .head_tag      (q_head_tag),
        .pop           (q_pop),
        .cnt_valid     (cnt_valid),
        .cnt_is_zero   (c_zero),
        .cnt_beyond    (c_beyond),
        .cnt_final_idx (c_final),
        .uop_valid     (uop_valid),
        .uop_ready     (uop_ready),
        .uop_kind      (kind_e),
        .uop_idx       (uop_idx),
        .uop_tag       (uop_tag),
        .uop_last      (uop_last)
    );

endmodule

// File: tb/copy_useq_tb.sv
module copy_useq_tb;
    localparam int N = 8;

    logic        clk = 0, rst = 1;
    logic        in_valid = 0, in_rep = 0;
    logic [7:0]  in_tag = 0;
    logic        in_ready;
    logic        uop_valid, uop_ready, uop_last;
    logic [2:0]  uop_kind;
    logic [15:0] uop_idx;
    logic [7:0]  uop_tag;
    logic        cnt_valid = 0;
    logic [15:0] cnt_value = 0;

    always #10 clk = ~clk;

    copy_useq u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_rep(in_rep), .in_tag(in_tag), .uop_valid(uop_valid),
        .uop_ready(uop_ready), .uop_kind(uop_kind), .uop_idx(uop_idx),
        .uop_tag(uop_tag), .uop_last(uop_last), .cnt_valid(cnt_valid),
        .cnt_value(cnt_value)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    int e_kind [0:2047];
    int e_idx  [0:2047];
    int e_tag  [0:2047];
    int e_last [0:2047];
    int wr = 0, rd = 0;
    logic [15:0] cnt_mem [0:255];

    bit stall_en = 0;
    logic [7:0] lfsr = 8'hA5;
    int ret_delay = 2;
    bit rep_pending = 0;
    logic [7:0] rep_tag = 0;

    // each entry: {rep, count}
    localparam logic [16:0] VEC [0:9] = '{
        {1'b0, 16'd0},  {1'b1, 16'd0},  {1'b1, 16'd1},  {1'b1, 16'd8},
        {1'b1, 16'd9},  {1'b0, 16'd0},  {1'b1, 16'd20}, {1'b1, 16'd5},
        {1'b0, 16'd0},  {1'b1, 16'd40}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_uop(input int k, input int i, input int t, input int l);
        e_kind[wr] = k; e_idx[wr] = i; e_tag[wr] = t; e_last[wr] = l;
        wr++;
    endtask

    task automatic model(input bit rep, input int tag, input int cnt);
        if (!rep) begin
            expect_uop(0, 0, tag, 1);
        end else begin
            for (int i = 0; i < N; i++) expect_uop(1, i, tag, 0);
            expect_uop(2, 0, tag, 0);
            if (cnt == 0) expect_uop(5, 0, tag, 1);
            else if (cnt <= N) expect_uop(4, 0, tag, 1);
            else for (int i = N; i < cnt; i++) expect_uop(3, i, tag, (i == cnt - 1) ? 1 : 0);
        end
    endtask

    // returns 1 when accepted at the first opportunity
    task automatic push(input bit rep, input logic [7:0] tag, input logic [15:0] cnt, output bit first);
        cnt_mem[tag] = cnt;
        model(rep, int'(tag), int'(cnt));
        @(posedge clk); #2;
        in_valid = 1; in_rep = rep; in_tag = tag;
        first = 1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            first = 0;
        end
        @(posedge clk); #2;
        in_valid = 0;
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 6) begin
            @(negedge clk);
            if (rd == wr && !uop_valid && !rep_pending) quiet++; else quiet = 0;
        end
    endtask

    // ready driver
    initial forever begin
        @(posedge clk); #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        uop_ready = stall_en ? lfsr[0] : 1'b1;
    end

    // back-end model: returns the stored count after a delay
    initial forever begin
        @(posedge clk);
        if (rep_pending) begin
            repeat (ret_delay) @(posedge clk);
            #2;
            cnt_valid = 1; cnt_value = cnt_mem[rep_tag];
            @(posedge clk); #2;
            cnt_valid = 0; cnt_value = 16'hFFFF;
            rep_pending = 0;
        end
    end

    // monitor
    initial begin
        bit pv = 0, pr = 0, pl = 0, waiting = 0;
        logic [2:0] pk = 0; logic [15:0] pi = 0; logic [7:0] pt = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pv && !pr)  // R10
                    check(uop_valid && uop_kind == pk && uop_idx == pi && uop_tag == pt && uop_last == pl,
                          "R10 hold", int'(uop_idx), int'(pi));
                if (waiting && uop_valid) check(0, "R5 silent wait", 1, 0);
                if (cnt_valid) waiting = 0;
                if (uop_valid && uop_ready) begin
                    if (rd >= wr) begin
                        check(0, "R4 unexpected uop kind", int'(uop_kind), -1);
                    end else begin
                        string req;
                        case (e_kind[rd])
                            0: req = "R2"; 1: req = "R3"; 2: req = "R3";
                            3: req = "R6"; 4: req = "R7"; default: req = "R8";
                        endcase
                        check(int'(uop_kind) == e_kind[rd], {req, " kind"}, int'(uop_kind), e_kind[rd]);
                        check(int'(uop_idx) == e_idx[rd], {req, " index"}, int'(uop_idx), e_idx[rd]);
                        check(int'(uop_tag) == e_tag[rd], "R9 tag", int'(uop_tag), e_tag[rd]);
                        check(int'(uop_last) == e_last[rd], "R9 last", int'(uop_last), e_last[rd]);
                        rd++;
                    end
                    if (uop_kind == 3'd2) begin
                        waiting = 1; rep_pending = 1; rep_tag = uop_tag;
                    end
                end
                pv = uop_valid; pr = uop_ready; pk = uop_kind; pi = uop_idx; pt = uop_tag; pl = uop_last;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit first;
        uop_ready = 1;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check(!uop_valid, "R1 valid after reset", int'(uop_valid), 0);
        check(in_ready, "R1 ready after reset", int'(in_ready), 1);

        // table walk; stalls on the second half
        for (int v = 0; v < 10; v++) begin
            stall_en = (v >= 5);
            push(VEC[v][16], 8'(v + 1), VEC[v][15:0], first);
        end
        drain();
        stall_en = 0;

        // R5: stray count return while idle has no effect
        @(posedge clk); #2;
        cnt_valid = 1; cnt_value = 16'd100;
        @(posedge clk); #2;
        cnt_valid = 0;
        @(negedge clk);
        check(!uop_valid, "R5 stray count idle", int'(uop_valid), 0);
        push(1'b1, 8'h30, 16'd2, first);   // expects end marker, not copies
        drain();

        // R4: queue fills while expansion waits for a slow count
        ret_delay = 30;
        push(1'b1, 8'h40, 16'd12, first);
        for (int k = 0; k < 3; k++) begin
            push(1'b0, 8'(8'h41 + k), 16'd0, first);
            check(first, "R4 queue accepts during expansion", int'(first), 1);
        end
        drain();
        ret_delay = 2;

        // R8 zero under stalls, R6 at batch+1 boundary back to back
        stall_en = 1;
        push(1'b1, 8'h50, 16'd0, first);
        push(1'b1, 8'h51, 16'd9, first);
        push(1'b0, 8'h52, 16'd0, first);
        drain();

        check(rd == wr, "R9 all expected uops seen", rd, wr);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule